// File: doc/BRIEF.md
# Microcoded Instruction Decoder with Conditional Branch Resolution

This block sits between the instruction register and the rest of a five-stage pipeline. It takes a 32-bit instruction and the four ALU status flags: greater, equal, less and carry. The upper byte of the instruction is the opcode. The opcode addresses a 256-entry control store of 32-bit microwords, and that store is computed as combinational logic. The selected microword is split into its control groups:

- the addressing-mode selects
- the execution-unit control
- the branch condition
- the memory control
- the write-back routing
- the register-file strobes
- the condition-invert bit

Every output is registered. All results appear one clock after the instruction and flags are sampled.

The block also decodes the operand fields, and the addressing mode decides how they are read. A register-register instruction yields a destination index and two source indices. An immediate or memory instruction yields one register index and a 16-bit immediate.

Conditional jumps are resolved in the same cycle as the decode. A 3-bit condition code picks one flag, or picks "always". A separate invert bit complements that choice. Because of this, each negated jump shares the comparator path of its positive form. When a jump is taken, the block outputs the low byte of the immediate as the target.

Top module: `udec_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is cleared to zero on that edge.
- R2: `uword` holds the microword for the opcode `instr[31:24]`. Opcodes 0x23 to 0xFF have no defined microword and decode as the no-op word 0x00008000. The defined microwords are:

| Opcode | Instruction | Microword |
|---|---|---|
| 0x00 | no-op | 0x00008000 |
| 0x01 | move-immediate | 0x8C005000 |
| 0x02 | add | 0x20007000 |
| 0x11 | compare | 0x3E002000 |
| 0x13 | register print | 0x2C022000 |
| 0x19 | double-word load | 0x4C395000 |
| 0x1A | jump-if-greater | 0x8C400000 |
| 0x1B | jump-if-equal | 0x8C800000 |
| 0x1C | jump-if-less | 0x8CC00000 |
| 0x1D | jump-if-carry | 0x8D000000 |
| 0x1E to 0x21 | negated jumps | positive word with bit 11 set |
| 0x22 | unconditional jump | 0x8D400000 |

- R3: Every output reflects the `instr` and flags sampled at the previous rising edge. Nothing passes through combinationally.
- R4: The microword fields come out on these ports:

| Microword bits | Port |
|---|---|
| 31 | `mode_imm` |
| 30 | `mode_mem` |
| 29 | `mode_rr` |
| 28:25 | `exe_ctl` |
| 24:22 | `cond_code` |
| 21:18 | `mem_ctl` |
| 17 | `wb_to_term` |
| 16 | `wb_from_mem` |
| 15 | `nop_flag` |
| 14 | `rf_we` |
| 13 | `rf_oe` |
| 12 | `rf_wsel` |
| 11 | `cond_inv` |

- R5: In register-register mode the operand ports are `rd_idx`=`instr[18:16]`, `rs1_idx`=`instr[10:8]` and `rs2_idx`=`instr[2:0]`, and `imm` is 0.
- R6: In immediate or memory mode the operand ports are `rd_idx`=`instr[18:16]` and `imm`=`instr[15:0]`, and both source indices are 0. When no mode bit is set, all operand ports are 0.
- R7: The condition codes are 001 greater, 010 equal, 011 less, 100 carry and 101 always. A branch is taken only when `mode_imm` is 1 and the selected condition is true.
- R8: When `cond_inv` is 1 the selected condition is complemented. This applies to code 101 as well, which then never branches.
- R9: Codes 000, 110 and 111 never branch, whatever the invert bit and the flags.
- R10: `br_target` equals `instr[7:0]` when `br_taken` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr | input | 32 | Instruction register contents |
| flag_gt | input | 1 | ALU greater flag |
| flag_eq | input | 1 | ALU equal flag |
| flag_lt | input | 1 | ALU less flag |
| flag_cy | input | 1 | ALU carry flag |
| uword | output | 32 | Registered control-store word |
| mode_imm | output | 1 | Immediate mode select |
| mode_mem | output | 1 | Memory mode select |
| mode_rr | output | 1 | Register-register mode select |
| exe_ctl | output | 4 | Execution unit control |
| cond_code | output | 3 | Branch condition code |
| mem_ctl | output | 4 | Memory control group |
| wb_to_term | output | 1 | Route write-back to terminal output path |
| wb_from_mem | output | 1 | Write-back source is memory (else ALU) |
| nop_flag | output | 1 | No-operation marker |
| rf_we | output | 1 | Register write |
| rf_oe | output | 1 | Register output enable |
| rf_wsel | output | 1 | Register write-select enable |
| cond_inv | output | 1 | Condition invert bit |
| rd_idx | output | 3 | Destination / single register index |
| rs1_idx | output | 3 | Source 1 register index |
| rs2_idx | output | 3 | Source 2 register index |
| imm | output | 16 | Immediate operand |
| br_taken | output | 1 | Conditional jump resolved as taken |
| br_target | output | 8 | Jump target address |

## Verification
Each output is due exactly one rising edge after the instruction and flags that produce it. The driver changes inputs on the falling edge and queues the expected record at the same moment. The monitor pops that record 2 ns after the next rising edge, so it always compares against the single edge that captured the stimulus. The two reserved condition codes cannot be reached through the fixed control store. They are therefore exercised on a separate instance of the combinational condition resolver, sampled 1 ns after its inputs change.

// File: rtl/udec_pkg.sv
// Package udec_pkg
// Shared widths, opcode numbers, condition encodings and the decoded
// control-group structure used by every module of the decoder.
// Assumes a 32-bit microword whose bit positions are fixed by the
// downstream pipeline stages that consume the individual groups.
package udec_pkg;

    localparam int WORD_W = 32;
    localparam int OPC_W  = 8;
    localparam int RIDX_W = 3;
    localparam int IMM_W  = 16;
    localparam int TGT_W  = 8;
    localparam int EXE_W  = 4;
    localparam int CND_W  = 3;
    localparam int MEMC_W = 4;
    localparam int NFLAG  = 4;

    // Microword bit positions consumed downstream
    localparam int B_MIMM  = 31;
    localparam int B_MMEM  = 30;
    localparam int B_MRR   = 29;
    localparam int B_EXE_L = 25;
    localparam int B_CND_L = 22;
    localparam int B_MEM_L = 18;
    localparam int B_WBT   = 17;
    localparam int B_WBM   = 16;
    localparam int B_NOP   = 15;
    localparam int B_WE    = 14;
    localparam int B_OE    = 13;
    localparam int B_WSEL  = 12;
    localparam int B_INV   = 11;

    // Instruction field positions
    localparam int F_RD_L  = 16;
    localparam int F_RS1_L = 8;
    localparam int F_RS2_L = 0;

    localparam logic [WORD_W-1:0] UW_IDLE = 32'h0000_8000;

    typedef enum logic [CND_W-1:0] {
        CC_NONE   = 3'd0,
        CC_GT     = 3'd1,
        CC_EQ     = 3'd2,
        CC_LT     = 3'd3,
        CC_CY     = 3'd4,
        CC_ALWAYS = 3'd5,
        CC_RSV6   = 3'd6,
        CC_RSV7   = 3'd7
    } cond_e;

    typedef struct packed {
        logic              m_imm;
        logic              m_mem;
        logic              m_rr;
        logic [EXE_W-1:0]  exe;
        cond_e             cc;
        logic [MEMC_W-1:0] memc;
        logic              wb_term;
        logic              wb_mem;
        logic              nop;
        logic              rf_we;
        logic              rf_oe;
        logic              rf_wsel;
        logic              cinv;
    } uctl_t;

endpackage

// File: rtl/udec_rom.sv
// Module udec_rom
// Control store: maps an opcode to its 32-bit microword. Written as
// combinational logic so it synthesizes to gates rather than a RAM.
// Assumes opcodes without a defined microword act as the idle word.
module udec_rom
    import udec_pkg::*;
(
    input  logic [OPC_W-1:0]  opc,
    output logic [WORD_W-1:0] word
);

    // Look up the microword for the current opcode
    always_comb begin
        case (opc)
            8'h00: word = 32'h0000_8000;  // idle
            8'h01: word = 32'h8C00_5000;  // load immediate into register
            8'h02: word = 32'h2000_7000;  // add
            8'h03: word = 32'h2200_7000;  // add with carry
            8'h04: word = 32'h2400_7000;  // subtract
            8'h05: word = 32'h2600_7000;  // subtract with borrow
            8'h06: word = 32'h2800_7000;  // multiply
            8'h07: word = 32'h2A00_7000;  // divide
            8'h08: word = 32'h2C00_7000;  // pass source 1
            8'h09: word = 32'h2E00_7000;  // pass source 2
            8'h0A: word = 32'h3000_7000;  // and
            8'h0B: word = 32'h3200_7000;  // or
            8'h0C: word = 32'h3400_7000;  // nand
            8'h0D: word = 32'h3600_7000;  // nor
            8'h0E: word = 32'h3800_7000;  // xor
            8'h0F: word = 32'h3A00_7000;  // xnor
            8'h10: word = 32'h3C00_7000;  // not
            8'h11: word = 32'h3E00_2000;  // compare
            8'h12: word = 32'h4C02_2000;  // print immediate
            8'h13: word = 32'h2C02_2000;  // print register
            8'h14: word = 32'h4C10_2000;  // store even word
            8'h15: word = 32'h4C14_2000;  // store odd word
            8'h16: word = 32'h4C30_2000;  // store double word
            8'h17: word = 32'h4C19_5000;  // load even word
            8'h18: word = 32'h4C1D_5000;  // load odd word
            8'h19: word = 32'h4C39_5000;  // load double word
            8'h1A: word = 32'h8C40_0000;  // jump if greater
            8'h1B: word = 32'h8C80_0000;  // jump if equal
            8'h1C: word = 32'h8CC0_0000;  // jump if less
            8'h1D: word = 32'h8D00_0000;  // jump if carry
            8'h1E: word = 32'h8C40_0800;  // jump if not greater
            8'h1F: word = 32'h8C80_0800;  // jump if not equal
            8'h20: word = 32'h8CC0_0800;  // jump if not less
            8'h21: word = 32'h8D00_0800;  // jump if not carry
            8'h22: word = 32'h8D40_0000;  // jump always
            default: word = UW_IDLE;
        endcase
    end

endmodule

// File: rtl/udec_split.sv
// Module udec_split
// Breaks a microword into its control groups and extracts operand
// fields from the instruction according to the addressing mode.
// Assumes at most one mode bit is set in any microword.
module udec_split
    import udec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] instr,
    output uctl_t             ctl,
    output logic [RIDX_W-1:0] rd,
    output logic [RIDX_W-1:0] rs1,
    output logic [RIDX_W-1:0] rs2,
    output logic [IMM_W-1:0]  imm
);

    logic unused_word_low;
    logic unused_instr_bits;

    // Bits of the word and instruction that carry no field here
    assign unused_word_low   = ^word[B_INV-1:0];
    assign unused_instr_bits = ^{instr[WORD_W-1:F_RD_L+RIDX_W]};

    // Slice the microword into named control groups
    always_comb begin
        ctl.m_imm   = word[B_MIMM];
        ctl.m_mem   = word[B_MMEM];
        ctl.m_rr    = word[B_MRR];
        ctl.exe     = word[B_EXE_L +: EXE_W];
        ctl.cc      = cond_e'(word[B_CND_L +: CND_W]);
        ctl.memc    = word[B_MEM_L +: MEMC_W];
        ctl.wb_term = word[B_WBT];
        ctl.wb_mem  = word[B_WBM];
        ctl.nop     = word[B_NOP];
        ctl.rf_we   = word[B_WE];
        ctl.rf_oe   = word[B_OE];
        ctl.rf_wsel = word[B_WSEL];
        ctl.cinv    = word[B_INV];
    end

    // Pick operand fields according to the addressing mode
    always_comb begin
        rd  = '0;
        rs1 = '0;
        rs2 = '0;
        imm = '0;
        if (word[B_MRR]) begin
            rd  = instr[F_RD_L  +: RIDX_W];
            rs1 = instr[F_RS1_L +: RIDX_W];
            rs2 = instr[F_RS2_L +: RIDX_W];
        end else if (word[B_MIMM] || word[B_MMEM]) begin
            rd  = instr[F_RD_L +: RIDX_W];
            imm = instr[IMM_W-1:0];
        end
    end

endmodule

// File: rtl/udec_cond.sv
// Module udec_cond
// Resolves a jump condition from the code, the invert bit and the ALU
// flags. Negated jumps reuse the positive selection and only flip it.
// Assumes the flags are valid in the same cycle as the instruction.
module udec_cond
    import udec_pkg::*;
(
    input  logic  mode_imm,
    input  cond_e cc,
    input  logic  inv,
    input  logic  f_gt,
    input  logic  f_eq,
    input  logic  f_lt,
    input  logic  f_cy,
    output logic  taken
);

    logic sel;
    logic valid_cc;

    // Select the flag named by the condition code
    always_comb begin
        sel      = 1'b0;
        valid_cc = 1'b1;
        case (cc)
            CC_GT:     sel = f_gt;
            CC_EQ:     sel = f_eq;
            CC_LT:     sel = f_lt;
            CC_CY:     sel = f_cy;
            CC_ALWAYS: sel = 1'b1;
            default:   valid_cc = 1'b0;
        endcase
    end

    // Apply inversion; only immediate-mode words with a valid code branch
    assign taken = mode_imm && valid_cc && (sel ^ inv);

endmodule

// File: rtl/udec_top.sv
// Module udec_top
// Decoder top: control-store lookup, field split and branch resolution,
// with every result captured in one register stage.
// Assumes instr and the flags are stable around the rising edge.
module udec_top
    import udec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WORD_W-1:0]   instr,
    input  logic                flag_gt,
    input  logic                flag_eq,
    input  logic                flag_lt,
    input  logic                flag_cy,
    output logic [WORD_W-1:0]   uword,
    output logic                mode_imm,
    output logic                mode_mem,
    output logic                mode_rr,
    output logic [EXE_W-1:0]    exe_ctl,
    output logic [CND_W-1:0]    cond_code,
    output logic [MEMC_W-1:0]   mem_ctl,
    output logic                wb_to_term,
    output logic                wb_from_mem,
    output logic                nop_flag,
    output logic                rf_we,
    output logic                rf_oe,
    output logic                rf_wsel,
    output logic                cond_inv,
    output logic [RIDX_W-1:0]   rd_idx,
    output logic [RIDX_W-1:0]   rs1_idx,
    output logic [RIDX_W-1:0]   rs2_idx,
    output logic [IMM_W-1:0]    imm,
    output logic                br_taken,
    output logic [TGT_W-1:0]    br_target
);

    localparam logic [OPC_W-1:0] OPC_JUMP_ALWAYS = 8'h22;

    logic [WORD_W-1:0] word_d;
    uctl_t             ctl_d;
    uctl_t             ctl_q;
    logic [RIDX_W-1:0] rd_d, rs1_d, rs2_d;
    logic [IMM_W-1:0]  imm_d;
    logic              take_d;
    logic [TGT_W-1:0]  tgt_d;

    udec_rom u_rom (
        .opc  (instr[WORD_W-1 -: OPC_W]),
        .word (word_d)
    );

    udec_split u_split (
        .word  (word_d),
        .instr (instr),
        .ctl   (ctl_d),
        .rd    (rd_d),
        .rs1   (rs1_d),
        .rs2   (rs2_d),
        .imm   (imm_d)
    );

    udec_cond u_cond (
        .mode_imm (ctl_d.m_imm),
        .cc       (ctl_d.cc),
        .inv      (ctl_d.cinv),
        .f_gt     (flag_gt),
        .f_eq     (flag_eq),
        .f_lt     (flag_lt),
        .f_cy     (flag_cy),
        .taken    (take_d)
    );

    // Target is the low immediate byte, gated by the branch decision
    assign tgt_d = take_d ? instr[TGT_W-1:0] : '0;

    // Output register stage with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uword     <= '0;
            ctl_q     <= '0;
            rd_idx    <= '0;
            rs1_idx   <= '0;
            rs2_idx   <= '0;
            imm       <= '0;
            br_taken  <= 1'b0;
            br_target <= '0;
        end else begin
            uword     <= word_d;
            ctl_q     <= ctl_d;
            rd_idx    <= rd_d;
            rs1_idx   <= rs1_d;
            rs2_idx   <= rs2_d;
            imm       <= imm_d;
            br_taken  <= take_d;
            br_target <= tgt_d;
        end
    end

    assign mode_imm    = ctl_q.m_imm;
    assign mode_mem    = ctl_q.m_mem;
    assign mode_rr     = ctl_q.m_rr;
    assign exe_ctl     = ctl_q.exe;
    assign cond_code   = ctl_q.cc;
    assign mem_ctl     = ctl_q.memc;
    assign wb_to_term  = ctl_q.wb_term;
    assign wb_from_mem = ctl_q.wb_mem;
    assign nop_flag    = ctl_q.nop;
    assign rf_we       = ctl_q.rf_we;
    assign rf_oe       = ctl_q.rf_oe;
    assign rf_wsel     = ctl_q.rf_wsel;
    assign cond_inv    = ctl_q.cinv;

    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_imm, mode_mem, mode_rr})); // R4
    AST_JUMP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[WORD_W-1 -: OPC_W] == OPC_JUMP_ALWAYS) |=> (br_taken && br_target == $past(instr[TGT_W-1:0]))); // R3
    AST_BRANCH_IMM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> mode_imm); // R7
    AST_DEAD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 3'd0 || cond_code == 3'd6 || cond_code == 3'd7) |-> !br_taken); // R9
    AST_TARGET_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (br_target == imm[TGT_W-1:0])); // R10
    AST_TARGET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken |-> (br_target == '0)); // R10
    AST_RR_NO_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rr |-> (imm == '0)); // R5
    AST_NO_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_imm || mode_mem || mode_rr) |-> (rd_idx == '0 && imm == '0 && rs1_idx == '0)); // R6

endmodule

// File: tb/sim_udec_top.sv
`timescale 1ns/1ps
module sim_udec_top;
    import udec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [3:0]  flg = '0;   // {gt, eq, lt, cy}
    logic [31:0] uword;
    logic        mode_imm, mode_mem, mode_rr;
    logic [3:0]  exe_ctl;
    logic [2:0]  cond_code;
    logic [3:0]  mem_ctl;
    logic        wb_to_term, wb_from_mem, nop_flag, rf_we, rf_oe, rf_wsel, cond_inv;
    logic [2:0]  rd_idx, rs1_idx, rs2_idx;
    logic [15:0] imm;
    logic        br_taken;
    logic [7:0]  br_target;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] i;
        logic [3:0]  f;
        logic [31:0] w;
        string       tg;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    udec_top u0 (
        .clk(clk), .rst_n(rst_n), .instr(instr),
        .flag_gt(flg[3]), .flag_eq(flg[2]), .flag_lt(flg[1]), .flag_cy(flg[0]),
        .uword(uword), .mode_imm(mode_imm), .mode_mem(mode_mem), .mode_rr(mode_rr),
        .exe_ctl(exe_ctl), .cond_code(cond_code), .mem_ctl(mem_ctl),
        .wb_to_term(wb_to_term), .wb_from_mem(wb_from_mem), .nop_flag(nop_flag),
        .rf_we(rf_we), .rf_oe(rf_oe), .rf_wsel(rf_wsel), .cond_inv(cond_inv),
        .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .imm(imm),
        .br_taken(br_taken), .br_target(br_target)
    );

    // Standalone resolver instance for codes the control store never emits
    logic  c_mode, c_inv, c_taken;
    cond_e c_cc;
    logic [3:0] c_f;
    udec_cond u1 (
        .mode_imm(c_mode), .cc(c_cc), .inv(c_inv),
        .f_gt(c_f[3]), .f_eq(c_f[2]), .f_lt(c_f[1]), .f_cy(c_f[0]),
        .taken(c_taken)
    );

    task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tg, act, exp);
        end
    endtask

    function automatic logic exp_take(input logic [31:0] w, input logic [3:0] f);
        logic v;
        if (!w[31]) return 1'b0;
        case (w[24:22])
            3'd1: v = f[3];
            3'd2: v = f[2];
            3'd3: v = f[1];
            3'd4: v = f[0];
            3'd5: v = 1'b1;
            default: return 1'b0;
        endcase
        return v ^ w[11];
    endfunction

    task automatic drive(input logic [31:0] ins, input logic [3:0] f,
                         input logic [31:0] w, input string tg);
        item_t it;
        @(negedge clk);
        instr = ins;
        flg   = f;
        it.i = ins; it.f = f; it.w = w; it.tg = tg;
        q.push_back(it);
    endtask

    // Monitor: results are due one rising edge after the driving negedge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && q.size() > 0) begin
                item_t it;
                logic [2:0]  e_rd, e_r1, e_r2;
                logic [15:0] e_imm;
                logic        e_tk;
                it = q.pop_front();
                chk("R2 R3 word", uword, it.w);
                chk("R4 fields",
                    {11'd0, mode_imm, mode_mem, mode_rr, exe_ctl, cond_code, mem_ctl,
                     wb_to_term, wb_from_mem, nop_flag, rf_we, rf_oe, rf_wsel, cond_inv},
                    {11'd0, it.w[31:11]});
                e_rd = '0; e_r1 = '0; e_r2 = '0; e_imm = '0;
                if (it.w[29]) begin
                    e_rd = it.i[18:16]; e_r1 = it.i[10:8]; e_r2 = it.i[2:0];
                end else if (it.w[31] || it.w[30]) begin
                    e_rd = it.i[18:16]; e_imm = it.i[15:0];
                end
                chk(it.w[29] ? "R5 operands" : "R6 operands",
                    {7'd0, rd_idx, rs1_idx, rs2_idx, imm}, {7'd0, e_rd, e_r1, e_r2, e_imm});
                e_tk = exp_take(it.w, it.f);
                chk({it.tg, " R10 branch"}, {23'd0, br_taken, br_target},
                    {23'd0, e_tk, e_tk ? it.i[7:0] : 8'h00});
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        c_mode = 1'b0; c_cc = CC_NONE; c_inv = 1'b0; c_f = '0;
        // R1: reset clears outputs even with a taken jump presented
        instr = 32'h2200_005A;
        flg = 4'hF;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset word", uword, 32'h0);
        chk("R1 reset branch", {23'd0, br_taken, br_target}, 32'h0);
        chk("R1 reset fields",
            {mode_imm, mode_mem, mode_rr, nop_flag, rf_we, imm, rd_idx}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        drive(32'h0000_0000, 4'h0, 32'h0000_8000, "R9");   // idle
        drive(32'h0103_1234, 4'hF, 32'h8C00_5000, "R9");   // move-immediate, code 000
        drive(32'h02FD_FAF6, 4'h0, 32'h2000_7000, "R7");   // add
        drive(32'h1101_0203, 4'hF, 32'h3E00_2000, "R7");   // compare
        drive(32'h1306_0007, 4'h0, 32'h2C02_2000, "R7");   // register print
        drive(32'h1904_BEEF, 4'h0, 32'h4C39_5000, "R7");   // double-word load
        drive(32'h1A00_0011, 4'b1000, 32'h8C40_0000, "R7");
        drive(32'h1A00_0012, 4'b0111, 32'h8C40_0000, "R7");
        drive(32'h1B00_0021, 4'b0100, 32'h8C80_0000, "R7");
        drive(32'h1C00_0031, 4'b0010, 32'h8CC0_0000, "R7");
        drive(32'h1D00_0041, 4'b0001, 32'h8D00_0000, "R7");
        drive(32'h1D00_0042, 4'b1110, 32'h8D00_0000, "R7");
        drive(32'h1E00_0051, 4'b1000, 32'h8C40_0800, "R8");
        drive(32'h1E00_0052, 4'b0000, 32'h8C40_0800, "R8");
        drive(32'h1F00_0061, 4'b1011, 32'h8C80_0800, "R8");
        drive(32'h2000_0071, 4'b0010, 32'h8CC0_0800, "R8");
        drive(32'h2100_0081, 4'b1110, 32'h8D00_0800, "R8");
        drive(32'h2200_00A5, 4'b0000, 32'h8D40_0000, "R7");
        drive(32'h2305_1111, 4'hF, 32'h0000_8000, "R2");   // undefined opcode
        drive(32'hFF07_2222, 4'hF, 32'h0000_8000, "R2");   // undefined opcode
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);

        // R9: reserved codes never branch; R8: inverted always never branches
        for (int k = 0; k < 4; k++) begin
            c_mode = 1'b1;
            c_f    = 4'hF;
            c_inv  = k[0];
            c_cc   = k[1] ? CC_RSV7 : CC_RSV6;
            #1;
            chk("R9 reserved code", {31'd0, c_taken}, 32'd0);
        end
        c_cc = CC_ALWAYS; c_inv = 1'b1; c_f = 4'h0;
        #1;
        chk("R8 inverted always", {31'd0, c_taken}, 32'd0);
        c_inv = 1'b0; c_mode = 1'b0;
        #1;
        chk("R7 always outside immediate mode", {31'd0, c_taken}, 32'd0);
        finish_run();
    end

endmodule